// File: doc/BRIEF.md
# Video Sync Timing Meter

This block measures the timing of an incoming horizontal and vertical sync pair. It works in a single clock domain, `clk_i`, and counts reference ticks. The tick source is chosen by one select bit: either an internal reference strobe or an external reference strobe (up to 27 MHz). When the selected strobe is held high, every clock cycle is a tick. Both sync inputs are asynchronous. They pass through two-flop synchronizers, and only their rising (leading) edges and falling (trailing) edges are used.

For every frame the block works out four results:
- the longest line in the frame, in ticks;
- the number of lines in the frame;
- the width of the last horizontal sync pulse;
- whether the source is progressive or interlaced.

The source is taken as interlaced when, on alternate fields, a VSYNC leading edge lands near the middle of a line. In that case one frame covers both fields. No PLL-lock input exists, so nothing gates the measurement.

The four results are published together at each frame start. They can be read at any time through a combinational read port with an 8-bit address. Each counter saturates at all ones instead of wrapping.

Top module: `video_sync_meter`

## Requirements
- R1: The read port returns data combinationally from `rd_addr_i`, using this map:
  - 0x37: line count [7:0].
  - 0x38: bit 7 = 0, bit 6 = 0 (copy-protection detect, not implemented), bit 5 = progressive flag, bit 4 = 0, bits [3:0] = line count [11:8].
  - 0x39: clocks per line [7:0].
  - 0x3A: bits [7:4] = 0, bits [3:0] = clocks per line [11:8].
  - 0x3B: HSYNC width.
  - Any other address reads 0x00.
- R2: After reset every mapped register reads 0x00.
- R3: Clocks per line is the number of ticks from one HSYNC rising edge to the next. With a tick on every cycle, an 858-cycle line reads 858.
- R4: The reported clocks per line is the longest line that ended within the frame, not the most recent line.
- R5: Lines per frame is the number of HSYNC rising edges from one frame start to the next. Frames of 525 and of 750 lines read 525 and 750.
- R6: HSYNC width is the number of ticks from an HSYNC rising edge to its falling edge, taken from the last pulse before the frame start. With a tick every cycle, pulses of 63 and 14 cycles read 63 and 14.
- R7: A VSYNC rising edge is a mid-line edge when its phase, in ticks since the last HSYNC rising edge, is more than a quarter and less than three quarters of the previous line length.
  - A mid-line edge does not start a frame; it marks the frame as interlaced, and its lines keep adding to the same count.
  - The progressive flag reads 1 when the frame had no mid-line edge and 0 when it had one.
- R8: With `ref_sel_i` = 1 only `ext_tick_i` advances the counters. With `ref_sel_i` = 0 only `int_tick_i` advances them. A cycle without the selected tick adds nothing.
- R9: Clocks per line and lines per frame saturate at 4095, and HSYNC width saturates at 255.
- R10: Only a VSYNC rising edge that is not mid-line starts a frame.
  - All published values change together, on the cycle after such an edge, and hold otherwise.
  - The first frame start after reset publishes nothing.
- R11: HSYNC and VSYNC are each sampled through two flops before edge detection. A VSYNC rising edge is seen exactly two cycles after the input is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_sel_i | input | 1 | 1 selects the external tick, 0 the internal tick |
| int_tick_i | input | 1 | Internal reference tick strobe |
| ext_tick_i | input | 1 | External reference tick strobe |
| hsync_i | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_i | input | 1 | Vertical sync, active high, asynchronous |
| rd_addr_i | input | 8 | Status register address |
| rd_data_o | output | 8 | Status register data |

## Verification
The bench drives frames whose lines are not all the same length. A meter that reports the most recent line would read the short value instead of the long one.

An interlaced frame puts its second VSYNC at mid-line. A design that treats every VSYNC as a frame start would report about half the line count and a progressive flag of 1.

Separate runs push lines, frames and pulses past 4095 and 255. Counters that wrap instead of saturating would read small residues.

Other runs:
- Halve the selected tick rate while the unselected tick keeps running at full rate. A wrong select would show up as doubled counts.
- Feed HSYNC with no VSYNC after a frame. Results that are not held would change mid-frame.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int CNT_W  = 12;
    localparam int WID_W  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] REG_BASE    = 8'h37;
    localparam logic [ADDR_W-1:0] A_LINES_LO  = REG_BASE;
    localparam logic [ADDR_W-1:0] A_LINES_HI  = REG_BASE + 8'd1;
    localparam logic [ADDR_W-1:0] A_CLOCKS_LO = REG_BASE + 8'd2;
    localparam logic [ADDR_W-1:0] A_CLOCKS_HI = REG_BASE + 8'd3;
    localparam logic [ADDR_W-1:0] A_WIDTH     = REG_BASE + 8'd4;

    localparam int HI_BITS = CNT_W - DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] lines;
        logic [CNT_W-1:0] clocks;
        logic [WID_W-1:0] width;
        logic             prog;
    } meas_t;

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v, input logic inc);
        return (inc && (v != {CNT_W{1'b1}})) ? v + 1'b1 : v;
    endfunction

    function automatic logic [WID_W-1:0] wid_step(input logic [WID_W-1:0] v, input logic inc);
        return (inc && (v != {WID_W{1'b1}})) ? v + 1'b1 : v;
    endfunction

endpackage

// File: rtl/vsm_sync.sv
module vsm_sync #(
    parameter int NUM = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] async_i,
    output logic [NUM-1:0] level_o,
    output logic [NUM-1:0] rise_o,
    output logic [NUM-1:0] fall_o
);

    for (genvar g = 0; g < NUM; g++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stable;
            logic prev;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d.meta   = async_i[g];
            st_d.stable = st_q.meta;
            st_d.prev   = st_q.stable;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q <= '0;
            else         st_q <= st_d;
        end

        assign level_o[g] = st_q.stable;
        assign rise_o[g]  = st_q.stable & ~st_q.prev;
        assign fall_o[g]  = ~st_q.stable & st_q.prev;
    end

endmodule

// File: rtl/vsm_line_meter.sv
module vsm_line_meter
    import vsm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             hs_lvl_i,
    input  logic             hs_rise_i,
    input  logic             hs_fall_i,
    input  logic             clr_max_i,
    output logic [CNT_W-1:0] phase_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] last_len_o,
    output logic [CNT_W-1:0] frame_max_o,
    output logic [WID_W-1:0] width_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] max_len;
        logic [CNT_W-1:0] last_len;
        logic [WID_W-1:0] wcnt;
        logic [WID_W-1:0] wlast;
        logic             seen;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // line length: a rising edge closes the running line and starts a new one
        if (hs_rise_i) begin
            st_d.cnt  = {{(CNT_W-1){1'b0}}, tick_i};
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.last_len = st_q.cnt;
                if (st_q.cnt > st_q.max_len) st_d.max_len = st_q.cnt;
            end
        end else begin
            st_d.cnt = cnt_step(st_q.cnt, tick_i);
        end
        // the coincident closing line is already folded into frame_max_o
        if (clr_max_i) st_d.max_len = '0;
        // pulse width
        if (hs_rise_i)     st_d.wcnt = {{(WID_W-1){1'b0}}, tick_i};
        else if (hs_lvl_i) st_d.wcnt = wid_step(st_q.wcnt, tick_i);
        if (hs_fall_i)     st_d.wlast = st_q.wcnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o     = hs_rise_i ? '0 : st_q.cnt;
    assign count_o     = st_q.cnt;
    assign last_len_o  = st_q.last_len;
    assign frame_max_o = (hs_rise_i && st_q.seen && (st_q.cnt > st_q.max_len))
                         ? st_q.cnt : st_q.max_len;
    assign width_o     = st_q.wlast;

endmodule

// File: rtl/vsm_frame_tracker.sv
module vsm_frame_tracker
    import vsm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hs_rise_i,
    input  logic             vs_rise_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] last_len_i,
    input  logic [CNT_W-1:0] frame_max_i,
    input  logic [WID_W-1:0] width_i,
    output logic             pub_o,
    output meas_t            meas_o
);

    typedef struct packed {
        logic [CNT_W-1:0] lines;
        logic             mid_seen;
        logic             started;
        meas_t            meas;
    } frame_st_t;

    frame_st_t st_d, st_q;

    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] upper;
    logic             mid_edge;

    always_comb begin
        quarter  = last_len_i >> 2;
        upper    = last_len_i - quarter;
        mid_edge = (phase_i > quarter) && (phase_i < upper);
        pub_o    = vs_rise_i && !mid_edge && st_q.started;

        st_d = st_q;
        if (hs_rise_i) st_d.lines = cnt_step(st_q.lines, 1'b1);
        if (vs_rise_i) begin
            if (mid_edge) begin
                if (st_q.started) st_d.mid_seen = 1'b1;
            end else begin
                if (st_q.started) begin
                    st_d.meas.lines  = st_q.lines;
                    st_d.meas.clocks = frame_max_i;
                    st_d.meas.width  = width_i;
                    st_d.meas.prog   = ~st_q.mid_seen;
                end
                st_d.lines    = {{(CNT_W-1){1'b0}}, hs_rise_i};
                st_d.mid_seen = 1'b0;
                st_d.started  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign meas_o = st_q.meas;

endmodule

// File: rtl/vsm_regs.sv
module vsm_regs
    import vsm_pkg::*;
(
    input  meas_t             meas_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    always_comb begin
        unique case (rd_addr_i)
            A_LINES_LO:  rd_data_o = meas_i.lines[DATA_W-1:0];
            A_LINES_HI:  rd_data_o = {1'b0, 1'b0, meas_i.prog, 1'b0,
                                      meas_i.lines[CNT_W-1:DATA_W]};
            A_CLOCKS_LO: rd_data_o = meas_i.clocks[DATA_W-1:0];
            A_CLOCKS_HI: rd_data_o = {{(DATA_W-HI_BITS){1'b0}},
                                      meas_i.clocks[CNT_W-1:DATA_W]};
            A_WIDTH:     rd_data_o = meas_i.width;
            default:     rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/video_sync_meter.sv
module video_sync_meter
    import vsm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_sel_i,
    input  logic              int_tick_i,
    input  logic              ext_tick_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int SYNC_N = 2;
    localparam int HS_BIT = 0;
    localparam int VS_BIT = 1;

    logic [SYNC_N-1:0] sync_lvl, sync_rise, sync_fall;
    logic              tick;
    logic              hs_rise, vs_rise;
    logic [CNT_W-1:0]  phase, line_count, last_len, frame_max;
    logic [WID_W-1:0]  width;
    logic              frame_pub;
    meas_t             meas;

    assign tick = ref_sel_i ? ext_tick_i : int_tick_i;

    vsm_sync #(.NUM(SYNC_N)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({vsync_i, hsync_i}),
        .level_o (sync_lvl),
        .rise_o  (sync_rise),
        .fall_o  (sync_fall)
    );

    assign hs_rise = sync_rise[HS_BIT];
    assign vs_rise = sync_rise[VS_BIT];

    vsm_line_meter u_line (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .hs_lvl_i    (sync_lvl[HS_BIT]),
        .hs_rise_i   (hs_rise),
        .hs_fall_i   (sync_fall[HS_BIT]),
        .clr_max_i   (frame_pub),
        .phase_o     (phase),
        .count_o     (line_count),
        .last_len_o  (last_len),
        .frame_max_o (frame_max),
        .width_o     (width)
    );

    vsm_frame_tracker u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hs_rise_i   (hs_rise),
        .vs_rise_i   (vs_rise),
        .phase_i     (phase),
        .last_len_i  (last_len),
        .frame_max_i (frame_max),
        .width_i     (width),
        .pub_o       (frame_pub),
        .meas_o      (meas)
    );

    vsm_regs u_regs (
        .meas_i    (meas),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/video_sync_meter_chk.sv
module video_sync_meter_chk
    import vsm_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             vsync_i,
    input logic             vs_rise,
    input logic             hs_rise,
    input logic             tick,
    input logic [CNT_W-1:0] line_count,
    input logic             frame_pub,
    input meas_t            meas
);

    // R11: a detected VSYNC edge comes from the input two samples back
    p_sync_delay_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vs_rise |-> $past(vsync_i, 2));

    // R10: published results change only right after a frame start
    p_atomic_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_pub |=> $stable(meas));

    // R8: no selected tick and no line restart leaves the line count unchanged
    p_tick_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick && !hs_rise) |=> (line_count == $past(line_count)));

    // R9: a saturated line count stays saturated until the next line starts
    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((line_count == {CNT_W{1'b1}}) && !hs_rise) |=> (line_count == {CNT_W{1'b1}}));

endmodule

bind video_sync_meter video_sync_meter_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .vs_rise    (vs_rise),
    .hs_rise    (hs_rise),
    .tick       (tick),
    .line_count (line_count),
    .frame_pub  (frame_pub),
    .meas       (meas)
);

// File: tb/test_video_sync_meter.sv
module test_video_sync_meter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_sel = 1'b1;
    logic       int_tick = 1'b1;
    logic       ext_tick = 1'b1;
    logic       hs = 1'b0;
    logic       vs = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    bit         half_int = 1'b0;

    typedef struct {
        int    cpl;
        int    lpf;
        int    wid;
        bit    prog;
        string req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) int_tick <= half_int ? ~int_tick : 1'b1;

    video_sync_meter i_video_sync_meter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_sel_i  (ref_sel),
        .int_tick_i (int_tick),
        .ext_tick_i (ext_tick),
        .hsync_i    (hs),
        .vsync_i    (vs),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    function automatic int sat(int v, int lim);
        return (v > lim) ? lim : v;
    endfunction

    task automatic read_chk(string req, string what, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s %s @%02h: got %02h expected %02h", req, what, a, rd_data, exp);
        end
    endtask

    task automatic send_line(int len, int w, int vs_from, int vs_to);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            hs = (c < w);
            vs = (c >= vs_from) && (c < vs_to);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hs = 1'b0;
            vs = 1'b0;
        end
    endtask

    // driver: two frames, then a frame-start line that publishes the second one
    task automatic run_case(string req, int p, int w, int n, bit il, int long_idx, int extra,
                            int e_cpl, int e_lpf, int e_wid, bit e_prog);
        int   h;
        exp_t e;
        h = (n - 1) / 2;
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < n; l++) begin
                int len;
                len = p + ((l == long_idx) ? extra : 0);
                if (l == 0)                 send_line(len, w, 0, len);
                else if (il && l == h)      send_line(len, w, p / 2, len);
                else if (il && l == h + 1)  send_line(len, w, 0, p / 2);
                else                        send_line(len, w, 0, 0);
            end
        end
        send_line(p, w, 0, p);
        idle(30);
        e.cpl = e_cpl; e.lpf = e_lpf; e.wid = e_wid; e.prog = e_prog; e.req = req;
        last_exp = e;
        sb.push_back(e);
        idle(20);
    endtask

    // R10: HSYNC without any VSYNC must leave published values untouched
    task automatic run_hold();
        exp_t e;
        for (int l = 0; l < 40; l++) send_line(30, 5, 0, 0);
        idle(10);
        e = last_exp;
        e.req = "R10";
        sb.push_back(e);
        idle(20);
    endtask

    // monitor: pops expected items and compares the register window
    initial begin
        forever begin
            exp_t       e;
            logic [11:0] lv, cv;
            wait (sb.size() > 0);
            e  = sb.pop_front();
            lv = e.lpf[11:0];
            cv = e.cpl[11:0];
            read_chk(e.req, "lines lo",  8'h37, lv[7:0]);
            read_chk(e.req, "lines hi/prog", 8'h38, {2'b00, e.prog, 1'b0, lv[11:8]});
            read_chk(e.req, "clocks lo", 8'h39, cv[7:0]);
            read_chk(e.req, "clocks hi", 8'h3A, {4'h0, cv[11:8]});
            read_chk(e.req, "width",     8'h3B, e.wid[7:0]);
            read_chk("R1", "unmapped",   8'h3C, 8'h00);
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset values
        read_chk("R2", "reset lines lo",  8'h37, 8'h00);
        read_chk("R2", "reset lines hi",  8'h38, 8'h00);
        read_chk("R2", "reset clocks lo", 8'h39, 8'h00);
        read_chk("R2", "reset clocks hi", 8'h3A, 8'h00);
        read_chk("R2", "reset width",     8'h3B, 8'h00);
        read_chk("R1", "unmapped",        8'h36, 8'h00);
        read_chk("R1", "unmapped",        8'h00, 8'h00);

        // R3, R6, R11: 858-cycle lines, 63-cycle pulse, through the synchronizers
        run_case("R3", 858, 63, 8, 1'b0, -1, 0, 858, 8, 63, 1'b1);
        run_hold();
        // R6: 600-cycle lines with a 14-cycle pulse
        run_case("R6", 600, 14, 8, 1'b0, -1, 0, 600, 8, 14, 1'b1);
        // R5: 525 and 750 lines per frame
        run_case("R5", 12, 2, 525, 1'b0, -1, 0, 12, 525, 2, 1'b1);
        run_case("R5", 12, 2, 750, 1'b0, -1, 0, 12, 750, 2, 1'b1);
        // R7: mid-line field edge makes an interlaced frame of 525 lines
        run_case("R7", 12, 2, 525, 1'b1, -1, 0, 12, 525, 2, 1'b0);
        // R4: one long line in the middle of the frame
        run_case("R4", 100, 10, 6, 1'b0, 2, 40, 140, 6, 10, 1'b1);
        // R8: internal tick at half rate selected
        ref_sel  = 1'b0;
        half_int = 1'b1;
        run_case("R8", 200, 20, 5, 1'b0, -1, 0, 100, 5, 10, 1'b1);
        // R8: external tick selected, internal tick keeps toggling
        ref_sel = 1'b1;
        run_case("R8", 200, 20, 5, 1'b0, -1, 0, 200, 5, 20, 1'b1);
        half_int = 1'b0;
        // R9: saturation of line length, pulse width and line count
        run_case("R9", 4300, 8, 3, 1'b0, -1, 0, sat(4300, 4095), 3, 8, 1'b1);
        run_case("R9", 400, 300, 3, 1'b0, -1, 0, 400, 3, sat(300, 255), 1'b1);
        run_case("R9", 3, 1, 4100, 1'b0, -1, 0, 3, sat(4100, 4095), 1, 1'b1);

        wait (sb.size() == 0);
        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule